// File: doc/BRIEF.md
# Ethernet PHY Basic Control Register with Deferred Speed/Duplex Update

This block is the basic control word of an Ethernet PHY. Software reads and writes it through a plain 16-bit register port. It carries the link speed code, the duplex mode, a collision-signal test enable, an isolate enable and a self-clearing request to restart auto-negotiation.

Speed and duplex writes do not reconfigure the PHY at once. They land in a pending copy, which is the copy software reads back. Only three events move the pending copy into the active configuration that drives the output ports:

- a soft reset;
- a restart of auto-negotiation;
- leaving power-down.

After a hardware reset, the speed and duplex defaults are decoded from two 4-bit strap inputs.

The block also produces a one-cycle request for the auto-negotiation engine. It fires on release from hardware reset, after a soft reset, and after software writes the restart bit.

Top module: `phy_ctl_reg`

## Requirements
- R1: While `rst_n` is low the strap inputs are decoded into pending and active speed/duplex. The decode works as follows:
  - Let M be true when `strap_mode` matches xx01, 1x00, 001x or 0111.
  - The speed MSB is `aneg[3] | aneg[2] | M`.
  - The speed LSB is `aneg[3:1]==3'b001 && !M`.
  - Duplex is `{aneg[3],aneg[2],aneg[0]}==3'b001 | aneg[3]`.
  - Collision test, isolate and the restart bit reset to 0.
- R2: Read layout of `rd_data`:

  | Bit | Field |
  |---|---|
  | 13 | pending speed LSB |
  | 10 | isolate |
  | 9 | restart |
  | 8 | pending duplex (1 = full) |
  | 7 | collision test |
  | 6 | pending speed MSB |

  Speed codes are 00 = 10 Mbps, 01 = 100 Mbps, 10 = 1000 Mbps and 11 = reserved. `act_speed` is {MSB, LSB}.
- R3: Bits 5:0, 12:11 and 15:14 always read 0, and writing 1 to them changes no output.
- R4: A write with bit 9 clear updates the pending speed/duplex seen on read, but leaves `act_speed` and `act_full_dup` unchanged.
- R5: A write with bit 9 set has three effects:
  - At the same clock edge, the written speed/duplex become both pending and active.
  - Bit 9 reads 1 for the following cycle and then returns to 0.
  - `an_restart` is high for exactly the one cycle after the write.
- R6: A cycle with `soft_rst` high has these effects:
  - Collision test, isolate and the restart bit are cleared.
  - The pending speed/duplex are copied into the active ones.
  - A register write in that same cycle is discarded.
  - `an_restart` is high in the next cycle.
- R7: A high-to-low change of `pwr_down` copies pending speed/duplex to active. Entering power-down, or holding it at either level, does not.
- R8: `an_restart` is high in the first cycle after `rst_n` rises, and low in the cycle after that unless another restart cause occurred.
- R9: Bits 7 and 10 take effect on `col_test_en` and `isolate_en` at the edge that captures the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| strap_aneg | input | 4 | Auto-negotiation strap pins, sampled during reset |
| strap_mode | input | 4 | Mode strap pins, sampled during reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read data |
| soft_rst | input | 1 | Software reset request, one cycle |
| pwr_down | input | 1 | Power-down level |
| act_speed | output | 2 | Active speed code |
| act_full_dup | output | 1 | Active duplex, 1 = full |
| col_test_en | output | 1 | Collision-signal test enable |
| isolate_en | output | 1 | Isolate enable |
| an_restart | output | 1 | One-cycle auto-negotiation start request |

## Verification
The hardest state to reach is a pending value that differs from the active one at the moment an apply event arrives. Reaching it needs a plain write, then a later soft reset, restart write or power-down exit. The event may also coincide with another write, which makes the ordering matter.

The random stimulus writes random data every few cycles and toggles `pwr_down` in runs. It mixes in soft resets, including some in the same cycle as a write. Every strap combination is then swept through hardware resets so that all decode terms are exercised.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;
  localparam int unsigned REG_W     = 16;
  localparam int unsigned SPD_HI_B  = 6;
  localparam int unsigned COL_B     = 7;
  localparam int unsigned DUP_B     = 8;
  localparam int unsigned RESTART_B = 9;
  localparam int unsigned ISO_B     = 10;
  localparam int unsigned SPD_LO_B  = 13;

  typedef struct packed {
    logic [1:0] speed;
    logic       full_dup;
  } link_cfg_t;

  // Mode strap match term
  function automatic logic mode_hit(input logic [3:0] mode);
    logic h;
    h = (mode[1:0] == 2'b01)
      | (mode[3] & (mode[1:0] == 2'b00))
      | (mode[3:1] == 3'b001)
      | (mode == 4'b0111);
    return h;
  endfunction

  function automatic link_cfg_t strap_decode(input logic [3:0] aneg,
                                             input logic [3:0] mode);
    link_cfg_t c;
    logic m;
    m = mode_hit(mode);
    c.speed[1] = aneg[3] | aneg[2] | m;
    c.speed[0] = (aneg[3:1] == 3'b001) & ~m;
    c.full_dup = ({aneg[3], aneg[2], aneg[0]} == 3'b001) | aneg[3];
    return c;
  endfunction

  function automatic link_cfg_t wdata_cfg(input logic [REG_W-1:0] d);
    link_cfg_t c;
    c.speed    = {d[SPD_HI_B], d[SPD_LO_B]};
    c.full_dup = d[DUP_B];
    return c;
  endfunction
endpackage

// File: rtl/phy_ctl_strap.sv
module phy_ctl_strap
  import phy_ctl_pkg::*;
(
  input  logic [3:0] aneg_i,
  input  logic [3:0] mode_i,
  output link_cfg_t  cfg_o
);
  always_comb begin
    cfg_o = strap_decode(aneg_i, mode_i);
  end
endmodule

// File: rtl/phy_ctl_events.sv
module phy_ctl_events (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_restart_i,
  input  logic soft_rst_i,
  input  logic pwr_down_i,
  output logic apply_o,
  output logic pd_exit_o,
  output logic restart_bit_o,
  output logic an_restart_o
);
  logic boot_q, req_q, pd_q, restart_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q    <= 1'b1;
      req_q     <= 1'b0;
      pd_q      <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      boot_q    <= 1'b0;
      req_q     <= soft_rst_i | wr_restart_i;
      pd_q      <= pwr_down_i;
      restart_q <= wr_restart_i & ~soft_rst_i;
    end
  end

  assign pd_exit_o     = pd_q & ~pwr_down_i;
  assign apply_o       = soft_rst_i | wr_restart_i | pd_exit_o;
  assign restart_bit_o = restart_q;
  assign an_restart_o  = rst_n & (boot_q | req_q);

  AST_PULSE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_i | wr_restart_i) |=> an_restart_o); // R5
  AST_RESTART_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_bit_o && !wr_restart_i) |=> !restart_bit_o); // R5
  AST_SWRST_NO_RESTART_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> !restart_bit_o); // R6
endmodule

// File: rtl/phy_ctl_shadow.sv
module phy_ctl_shadow
  import phy_ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  link_cfg_t strap_cfg_i,
  input  logic      wr_i,
  input  link_cfg_t wr_cfg_i,
  input  logic      wr_col_i,
  input  logic      wr_iso_i,
  input  logic      soft_rst_i,
  input  logic      apply_i,
  input  logic      pd_exit_i,
  output link_cfg_t pend_o,
  output link_cfg_t act_o,
  output logic      col_o,
  output logic      iso_o
);
  link_cfg_t pend_q, act_q, pend_nxt;
  logic      col_q, iso_q;

  always_comb begin
    pend_nxt = pend_q;
    if (!soft_rst_i && wr_i) pend_nxt = wr_cfg_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= strap_cfg_i;
      act_q  <= strap_cfg_i;
      col_q  <= 1'b0;
      iso_q  <= 1'b0;
    end else begin
      pend_q <= pend_nxt;
      if (apply_i) act_q <= pend_nxt;
      if (soft_rst_i) begin
        col_q <= 1'b0;
        iso_q <= 1'b0;
      end else if (wr_i) begin
        col_q <= wr_col_i;
        iso_q <= wr_iso_i;
      end
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;
  assign col_o  = col_q;
  assign iso_o  = iso_q;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_i |=> $stable(act_q)); // R4
  AST_APPLY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    apply_i |=> (act_q == pend_q)); // R6
  AST_PDEXIT_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_exit_i && !wr_i) |=> (act_q == $past(pend_q))); // R7
  AST_SWRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> (!col_q && !iso_q && $stable(pend_q))); // R6
endmodule

// File: rtl/phy_ctl_reg.sv
module phy_ctl_reg
  import phy_ctl_pkg::*;
#(
  parameter int unsigned DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        strap_aneg,
  input  logic [3:0]        strap_mode,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              soft_rst,
  input  logic              pwr_down,
  output logic [1:0]        act_speed,
  output logic              act_full_dup,
  output logic              col_test_en,
  output logic              isolate_en,
  output logic              an_restart
);
  link_cfg_t strap_cfg, pend_cfg, act_cfg, wr_cfg;
  logic      wr_restart, apply_evt, pd_exit, restart_bit, col_q, iso_q;

  assign wr_restart = wr_en & wr_data[RESTART_B] & ~soft_rst;
  assign wr_cfg     = wdata_cfg(wr_data[REG_W-1:0]);

  phy_ctl_strap u_strap (
    .aneg_i (strap_aneg),
    .mode_i (strap_mode),
    .cfg_o  (strap_cfg)
  );

  phy_ctl_events u_evt (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_restart_i  (wr_restart),
    .soft_rst_i    (soft_rst),
    .pwr_down_i    (pwr_down),
    .apply_o       (apply_evt),
    .pd_exit_o     (pd_exit),
    .restart_bit_o (restart_bit),
    .an_restart_o  (an_restart)
  );

  phy_ctl_shadow u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_cfg_i (strap_cfg),
    .wr_i        (wr_en),
    .wr_cfg_i    (wr_cfg),
    .wr_col_i    (wr_data[COL_B]),
    .wr_iso_i    (wr_data[ISO_B]),
    .soft_rst_i  (soft_rst),
    .apply_i     (apply_evt),
    .pd_exit_i   (pd_exit),
    .pend_o      (pend_cfg),
    .act_o       (act_cfg),
    .col_o       (col_q),
    .iso_o       (iso_q)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[SPD_LO_B]  = pend_cfg.speed[0];
    rd_data[ISO_B]     = iso_q;
    rd_data[RESTART_B] = restart_bit;
    rd_data[DUP_B]     = pend_cfg.full_dup;
    rd_data[COL_B]     = col_q;
    rd_data[SPD_HI_B]  = pend_cfg.speed[1];
  end

  assign act_speed    = act_cfg.speed;
  assign act_full_dup = act_cfg.full_dup;
  assign col_test_en  = col_q;
  assign isolate_en   = iso_q;

  AST_ISO_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst) |=> (isolate_en == $past(wr_data[ISO_B]))); // R9
  AST_RESERVED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[5:0] == 6'd0)); // R3
endmodule

// File: tb/phy_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module phy_ctl_reg_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  strap_aneg = 0, strap_mode = 0;
  logic        wr_en = 0, soft_rst = 0, pwr_down = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic [1:0]  act_speed;
  logic        act_full_dup, col_test_en, isolate_en, an_restart;

  int checks = 0, errors = 0;
  logic [1:0] m_pspd, m_aspd;
  logic       m_pdup, m_adup, m_col, m_iso, m_rq, m_pulse, m_pdprev;

  always #5 clk = ~clk;

  phy_ctl_reg dut_i (.*);

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  function automatic logic b_m(input logic [3:0] md);
    casez (md)
      4'b??01, 4'b1?00, 4'b001?, 4'b0111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
  function automatic logic [1:0] b_spd(input logic [3:0] a, input logic [3:0] md);
    return {(a[3] || a[2] || b_m(md)), (a[3:1] == 3'b001 && !b_m(md))};
  endfunction
  function automatic logic b_dup(input logic [3:0] a);
    return a[3] ? 1'b1 : (!a[2] && !a[1] ? a[0] : (!a[2] && a[0]));
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd();
    logic [15:0] r = '0;
    r[13] = m_pspd[0]; r[10] = m_iso; r[9] = m_rq; r[8] = m_pdup;
    r[7] = m_col; r[6] = m_pspd[1];
    return r;
  endfunction

  task automatic compare(input string req);
    chk(req, "rd_data", rd_data, exp_rd());
    chk(req, "act_speed", act_speed, m_aspd);
    chk(req, "act_full_dup", act_full_dup, m_adup);
    chk(req, "col_test_en", col_test_en, m_col);
    chk(req, "isolate_en", isolate_en, m_iso);
    chk(req, "an_restart", an_restart, m_pulse);
  endtask

  // one clock step: inputs applied at negedge, model updated, compared at next negedge
  task automatic step(input logic w, input logic [15:0] wd, input logic sr,
                      input logic pd, input string req);
    logic [1:0] np; logic nd; logic ap;
    wr_en = w; wr_data = wd; soft_rst = sr; pwr_down = pd;
    @(posedge clk);
    np = m_pspd; nd = m_pdup;
    ap = sr || (w && wd[9]) || (m_pdprev && !pd);
    if (sr) begin
      m_col = 0; m_iso = 0; m_rq = 0;
    end else begin
      if (w) begin
        np = {wd[6], wd[13]}; nd = wd[8];
        m_col = wd[7]; m_iso = wd[10];
      end
      m_rq = w && wd[9];
    end
    m_pulse = sr || (w && wd[9]);
    m_pspd = np; m_pdup = nd;
    if (ap) begin m_aspd = np; m_adup = nd; end
    m_pdprev = pd;
    @(negedge clk);
    compare(req);
  endtask

  task automatic hw_reset(input logic [3:0] a, input logic [3:0] md);
    rst_n = 0; strap_aneg = a; strap_mode = md;
    wr_en = 0; soft_rst = 0; pwr_down = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_pspd = b_spd(a, md); m_aspd = m_pspd;
    m_pdup = b_dup(a); m_adup = m_pdup;
    m_col = 0; m_iso = 0; m_rq = 0; m_pdprev = 0;
    #1;
    m_pulse = 1; compare("R1"); // R8: first cycle after release
    @(negedge clk);
    m_pulse = 0; compare("R8");
  endtask

  initial begin
    void'($urandom(32'd20240613));
    @(negedge clk);
    hw_reset(4'b0010, 4'b0000);
    // R4: plain write changes pending only
    step(1, 16'h2140, 0, 0, "R4");
    step(0, 0, 0, 0, "R4");
    // R3: reserved bits written 1 read 0
    step(1, 16'hD83F, 0, 0, "R3");
    // R9: col/iso immediate
    step(1, 16'h0480, 0, 0, "R9");
    // R5: restart write applies and self-clears
    step(1, 16'h2300, 0, 0, "R5");
    step(0, 0, 0, 0, "R5");
    // R7: enter power-down no apply, exit applies
    step(1, 16'h0040, 0, 0, "R7");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 0, 1, "R7");
    step(0, 0, 0, 0, "R7");
    // R6: soft reset with simultaneous write discards write
    step(1, 16'h0580, 0, 0, "R6");
    step(1, 16'h2000, 1, 0, "R6");
    step(0, 0, 0, 0, "R6");
    // R2 random mix
    for (int i = 0; i < 3000; i++) begin
      logic w, sr, pd; logic [15:0] wd;
      w  = ($urandom % 3) == 0;
      wd = 16'($urandom);
      if (($urandom % 4) != 0) wd[9] = 0;
      sr = ($urandom % 23) == 0;
      pd = (($urandom % 7) == 0) ? ~pwr_down : pwr_down;
      step(w, wd, sr, pd, "R2");
    end
    // R1 strap sweep
    for (int s = 0; s < 256; s++) hw_reset(s[7:4], s[3:0]);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule